// File: doc/BRIEF.md
# Multichannel DMA Control and Status Register Block

This block holds the global control and status registers of a DMA controller that has four or eight channels. Software reaches it over a simple 32-bit memory-mapped slave port, which has an address, a write enable, write data and a combinational read-data return. The block packs a transfer mode and a direction for each channel into one control word. A second control word carries the per-channel interrupt enables together with self-clearing start bits. A status word gathers the sticky completion flags, the sticky error flags and a live 2-bit activity state for every channel. A general-purpose scratch control word completes the set.

Toward the channel engines, the block drives a one-cycle start pulse, a 2-bit mode and a direction bit for each channel. In return it receives per-channel completion and error event pulses and the current activity state. A single interrupt line, shared by all channels, is raised whenever a flagged channel has its enable set. Software acknowledges a flag by writing a 1 back to its position.

Top module: `mchan_dma_csr`

## Requirements
- R1: After reset every register reads 0. Offset 0x14 and the unused offsets 0x0C, 0x18 and 0x1C always read 0, and writes to them change nothing.
- R2: The word at 0x00 holds a 4-bit field for channel n at bits [4n+3:4n]. Bits [1:0] of that field are the mode (0 off, 1 descriptor chain, 2 single block), bit 2 is the direction (1 = memory to device, 0 = device to memory), and bit 3 reads 0. The `ch_mode` and `ch_dir` outputs show the new value on the cycle after the write.
- R3: Writing mode 0 into a channel's field drives that channel's `ch_mode` to 0 on the next cycle. The channel engine takes this as a command to stop and abandon its transfer.
- R4: The word at 0x04 is a 32-bit read/write scratch register.
- R5: In the word at 0x08, bits [NCH-1:0] are the per-channel interrupt enables and are read/write. Enable bits at or above NCH, and all bits above 15, read 0.
- R6: Writing 1 to bit 8+n of 0x08 raises `ch_start[n]` for exactly the one cycle after the write. The start bits always read back as 0.
- R7: A start request for a channel whose `ch_state` field is not 0 (idle) in the write cycle is dropped, and no pulse is produced.
- R8: In the word at 0x10, bit n is a sticky flag set by `ch_done[n]` or `ch_err[n]`. Bit 8+n is a sticky flag set by `ch_err[n]` only.
- R9: Bits [16+2n+1:16+2n] of 0x10 show `ch_state` for channel n live: 0 idle, 1 fetching a descriptor, 2 waiting, 3 moving data. Writes do not affect these bits.
- R10: Writing 1 to a flag position in 0x10 clears that flag on the next cycle. Writing 0 leaves it unchanged.
- R11: When an event and a clear of the same flag fall in the same cycle, the event wins and the flag stays set.
- R12: `irq` is high whenever some channel n has both its bit-n flag in 0x10 and its enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write enable, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ch_start | output | NCH | One-cycle start pulse per channel |
| ch_mode | output | 2*NCH | Mode per channel, channel n at [2n+1:2n] |
| ch_dir | output | NCH | Direction per channel, 1 = memory to device |
| ch_done | input | NCH | Completion event pulse per channel |
| ch_err | input | NCH | Error event pulse per channel |
| ch_state | input | 2*NCH | Live activity state per channel, channel n at [2n+1:2n] |
| irq | output | 1 | Shared interrupt request |

## Verification
The hardest case to reach from the ports is a completion event that lands in the exact cycle in which software writes the acknowledge for the same flag. A bus master working at ordinary speed would almost never produce this alignment. The stimulus produces it by first setting the flag, then driving the event pulse and the write-one-to-clear on the same falling edge, and finally reading the status word afterwards. The start guard is tested in a similar way: the stimulus holds a non-idle state on one channel while a single write requests starts on that channel and on an idle one.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;
  // Register byte offsets
  localparam int unsigned OFF_CTL0 = 'h00;
  localparam int unsigned OFF_CTL1 = 'h04;
  localparam int unsigned OFF_CTL2 = 'h08;
  localparam int unsigned OFF_STS0 = 'h10;
  localparam int unsigned OFF_STS1 = 'h14;

  // Field placement that channel engines and software decode
  localparam int unsigned NIB_W     = 4;
  localparam int unsigned START_LSB = 8;
  localparam int unsigned ERR_LSB   = 8;
  localparam int unsigned STATE_LSB = 16;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_CHAIN  = 2'd1,
    MODE_SINGLE = 2'd2
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_MOVE  = 2'd3
  } chan_state_e;
endpackage

// File: rtl/dmacsr_chan_ctl.sv
module dmacsr_chan_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl0_we,
  input  logic [2:0] nib_wdata,
  input  logic       ctl2_we,
  input  logic       ie_wdata,
  input  logic       start_wdata,
  input  logic       state_idle,
  output logic [1:0] mode,
  output logic       dir,
  output logic       ie,
  output logic       start
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode  <= 2'd0;
      dir   <= 1'b0;
      ie    <= 1'b0;
      start <= 1'b0;
    end else begin
      if (ctl0_we) begin
        mode <= nib_wdata[1:0];
        dir  <= nib_wdata[2];
      end
      if (ctl2_we) ie <= ie_wdata;
      // start bit is a strobe: never stored, only pulsed when idle
      start <= ctl2_we & start_wdata & state_idle;
    end
  end
endmodule

// File: rtl/dmacsr_chan_flags.sv
module dmacsr_chan_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_done,
  input  logic ev_err,
  input  logic clr_irq,
  input  logic clr_err,
  output logic irq_flag,
  output logic err_flag
);
  logic set_irq;
  assign set_irq = ev_done | ev_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_flag <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      // a set in the same cycle dominates the clear
      irq_flag <= (irq_flag & ~clr_irq) | set_irq;
      err_flag <= (err_flag & ~clr_err) | ev_err;
    end
  end
endmodule

// File: rtl/mchan_dma_csr.sv
module mchan_dma_csr
  import dmacsr_pkg::*;
#(
  parameter int unsigned NCH    = 8,
  parameter int unsigned ADDR_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NCH-1:0]       ch_start,
  output logic [2*NCH-1:0]     ch_mode,
  output logic [NCH-1:0]       ch_dir,
  input  logic [NCH-1:0]       ch_done,
  input  logic [NCH-1:0]       ch_err,
  input  logic [2*NCH-1:0]     ch_state,
  output logic                 irq
);
  localparam int unsigned ST_W = 2 * NCH;

  logic sel_ctl0, sel_ctl1, sel_ctl2, sel_sts0;
  logic [31:0]    ctl1_q;
  logic [NCH-1:0] ie;
  logic [NCH-1:0] irq_flg;
  logic [NCH-1:0] err_flg;

  assign sel_ctl0 = (bus_addr == ADDR_W'(OFF_CTL0));
  assign sel_ctl1 = (bus_addr == ADDR_W'(OFF_CTL1));
  assign sel_ctl2 = (bus_addr == ADDR_W'(OFF_CTL2));
  assign sel_sts0 = (bus_addr == ADDR_W'(OFF_STS0));

  always_ff @(posedge clk) begin
    if (!rst_n)                ctl1_q <= '0;
    else if (bus_wr && sel_ctl1) ctl1_q <= bus_wdata;
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    dmacsr_chan_ctl u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl0_we    (bus_wr & sel_ctl0),
      .nib_wdata  (bus_wdata[NIB_W*n +: 3]),
      .ctl2_we    (bus_wr & sel_ctl2),
      .ie_wdata   (bus_wdata[n]),
      .start_wdata(bus_wdata[START_LSB+n]),
      .state_idle (ch_state[2*n +: 2] == ST_IDLE),
      .mode       (ch_mode[2*n +: 2]),
      .dir        (ch_dir[n]),
      .ie         (ie[n]),
      .start      (ch_start[n])
    );

    dmacsr_chan_flags u_flg (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev_done (ch_done[n]),
      .ev_err  (ch_err[n]),
      .clr_irq (bus_wr & sel_sts0 & bus_wdata[n]),
      .clr_err (bus_wr & sel_sts0 & bus_wdata[ERR_LSB+n]),
      .irq_flag(irq_flg[n]),
      .err_flag(err_flg[n])
    );
  end

  logic [31:0] ctl0_rd, ctl2_rd, sts0_rd;

  always_comb begin
    ctl0_rd = '0;
    for (int n = 0; n < NCH; n++) begin
      ctl0_rd[NIB_W*n +: 3] = {ch_dir[n], ch_mode[2*n +: 2]};
    end
    ctl2_rd = '0;
    ctl2_rd[NCH-1:0] = ie;
    sts0_rd = '0;
    sts0_rd[NCH-1:0]              = irq_flg;
    sts0_rd[ERR_LSB +: NCH]       = err_flg;
    sts0_rd[STATE_LSB +: ST_W]    = ch_state;
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_ctl0)      bus_rdata = ctl0_rd;
    else if (sel_ctl1) bus_rdata = ctl1_q;
    else if (sel_ctl2) bus_rdata = ctl2_rd;
    else if (sel_sts0) bus_rdata = sts0_rd;
  end

  assign irq = |(irq_flg & ie);
endmodule

// File: rtl/mchan_dma_csr_chk.sv
module mchan_dma_csr_chk
  import dmacsr_pkg::*;
#(
  parameter int unsigned NCH    = 8,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic [NCH-1:0]    ch_start,
  input logic [2*NCH-1:0]  ch_mode,
  input logic [NCH-1:0]    ch_done,
  input logic [NCH-1:0]    ch_err,
  input logic [2*NCH-1:0]  ch_state,
  input logic [NCH-1:0]    ie,
  input logic [NCH-1:0]    irq_flg,
  input logic [NCH-1:0]    err_flg,
  input logic              irq
);
  logic wr_ctl0, wr_ctl2, wr_sts0;
  assign wr_ctl0 = bus_wr && (bus_addr == ADDR_W'(OFF_CTL0));
  assign wr_ctl2 = bus_wr && (bus_addr == ADDR_W'(OFF_CTL2));
  assign wr_sts0 = bus_wr && (bus_addr == ADDR_W'(OFF_STS0));

  for (genvar n = 0; n < NCH; n++) begin : g_chk
    // R2
    a_r2_mode_follows: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctl0 |=> ch_mode[2*n +: 2] == $past(bus_wdata[NIB_W*n +: 2]));
    // R6
    a_r6_start_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      ch_start[n] |-> $past(wr_ctl2 && bus_wdata[START_LSB+n]));
    // R7
    a_r7_start_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ch_start[n] |-> $past(ch_state[2*n +: 2] == ST_IDLE));
    // R8 and R11
    a_r11_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ch_done[n] |=> irq_flg[n]);
    a_r11_err_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ch_err[n] |=> err_flg[n] && irq_flg[n]);
    // R10
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sts0 && bus_wdata[n] && !ch_done[n] && !ch_err[n]) |=> !irq_flg[n]);
    // R12
    a_r12_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flg[n] && ie[n]) |-> irq);
  end
endmodule

bind mchan_dma_csr mchan_dma_csr_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_wdata(bus_wdata),
  .ch_start (ch_start),
  .ch_mode  (ch_mode),
  .ch_done  (ch_done),
  .ch_err   (ch_err),
  .ch_state (ch_state),
  .ie       (ie),
  .irq_flg  (irq_flg),
  .err_flg  (err_flg),
  .irq      (irq)
);

// File: tb/mchan_dma_csr_bench.sv
module mchan_dma_csr_bench;
  localparam int NCH = 8;
  localparam int AW  = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic            bus_wr = 1'b0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NCH-1:0]  ch_start;
  logic [2*NCH-1:0] ch_mode;
  logic [NCH-1:0]  ch_dir;
  logic [NCH-1:0]  ch_done = '0;
  logic [NCH-1:0]  ch_err = '0;
  logic [2*NCH-1:0] ch_state = '0;
  logic            irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mchan_dma_csr #(.NCH(NCH), .ADDR_W(AW)) u_mchan_dma_csr (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_start(ch_start),
    .ch_mode(ch_mode), .ch_dir(ch_dir), .ch_done(ch_done), .ch_err(ch_err),
    .ch_state(ch_state), .irq(irq)
  );

  // {is_write, addr, wdata, expected read, requirement number}
  localparam int NV = 20;
  localparam logic [73:0] VEC [NV] = '{
    {1'b0, 5'h00, 32'h0, 32'h0, 4'd1},                 // R1
    {1'b0, 5'h04, 32'h0, 32'h0, 4'd1},                 // R1
    {1'b0, 5'h08, 32'h0, 32'h0, 4'd1},                 // R1
    {1'b0, 5'h10, 32'h0, 32'h0, 4'd1},                 // R1
    {1'b0, 5'h14, 32'h0, 32'h0, 4'd1},                 // R1
    {1'b1, 5'h00, 32'hFFFF_FFFF, 32'h0, 4'd2},         // R2
    {1'b0, 5'h00, 32'h0, 32'h7777_7777, 4'd2},         // R2 bit 3 reads 0
    {1'b1, 5'h00, 32'h0000_0651, 32'h0, 4'd2},
    {1'b0, 5'h00, 32'h0, 32'h0000_0651, 4'd2},         // R2
    {1'b1, 5'h04, 32'hDEAD_BEEF, 32'h0, 4'd4},
    {1'b0, 5'h04, 32'h0, 32'hDEAD_BEEF, 4'd4},         // R4
    {1'b1, 5'h08, 32'h0000_FFA5, 32'h0, 4'd5},
    {1'b0, 5'h08, 32'h0, 32'h0000_00A5, 4'd5},         // R5, start bits read 0
    {1'b1, 5'h0C, 32'h1234_5678, 32'h0, 4'd1},
    {1'b0, 5'h0C, 32'h0, 32'h0, 4'd1},                 // R1
    {1'b1, 5'h14, 32'hFFFF_FFFF, 32'h0, 4'd1},
    {1'b0, 5'h14, 32'h0, 32'h0, 4'd1},                 // R1
    {1'b1, 5'h1C, 32'hAAAA_AAAA, 32'h0, 4'd1},
    {1'b0, 5'h1C, 32'h0, 32'h0, 4'd1},                 // R1
    {1'b0, 5'h04, 32'h0, 32'hDEAD_BEEF, 4'd4}          // R4 untouched
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic pulse_done(input int n);
    @(negedge clk); ch_done[n] = 1'b1;
    @(negedge clk); ch_done[n] = 1'b0;
  endtask

  task automatic pulse_err(input int n);
    @(negedge clk); ch_err[n] = 1'b1;
    @(negedge clk); ch_err[n] = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    check("R1 start after reset", {24'b0, ch_start}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][73]) begin
        wr(VEC[i][72:68], VEC[i][67:36]);
      end else begin
        rd(VEC[i][72:68], r);
        check($sformatf("R%0d vector %0d", VEC[i][3:0], i), r, VEC[i][35:4]);
      end
    end

    // R2 outputs reflect control 0 = 0x651
    wr(5'h00, 32'h0000_0651);
    check("R2 mode out", {26'b0, ch_mode[5:0]}, {26'b0, 6'b10_01_01});
    check("R2 dir out", {29'b0, ch_dir[2:0]}, {29'b0, 3'b110});

    // R3 mode 0 disables
    wr(5'h00, 32'h0);
    check("R3 mode cleared", {16'b0, ch_mode}, 32'h0);

    // R9 live state, read-only
    ch_state = 16'h9C63;
    rd(5'h10, r);
    check("R9 state live", r, 32'h9C63_0000);
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h10, r);
    check("R9 state read-only", r, 32'h9C63_0000);
    ch_state = '0;

    // R7 start on busy channel 3 ignored, channel 2 idle starts
    ch_state[7:6] = 2'b10;
    wr(5'h08, 32'h0000_0C00);
    check("R7 start guarded", {24'b0, ch_start}, 32'h0000_0004);
    ch_state = '0;
    @(negedge clk);

    // R6 one-cycle start pulse, reads back 0
    wr(5'h08, 32'h0000_0100);
    check("R6 start pulse", {24'b0, ch_start}, 32'h1);
    @(negedge clk);
    check("R6 start one cycle", {24'b0, ch_start}, 32'h0);
    rd(5'h08, r);
    check("R6 start reads 0", r, 32'h0);

    // R8 flags set by events
    pulse_done(1);
    rd(5'h10, r);
    check("R8 done flag", r, 32'h0000_0002);
    pulse_err(5);
    rd(5'h10, r);
    check("R8 err flags", r, 32'h0000_2022);

    // R10 write-one-to-clear
    wr(5'h10, 32'h0);
    rd(5'h10, r);
    check("R10 zero write keeps", r, 32'h0000_2022);
    wr(5'h10, 32'h0000_0002);
    rd(5'h10, r);
    check("R10 clear one", r, 32'h0000_2020);
    wr(5'h10, 32'h0000_2020);
    rd(5'h10, r);
    check("R10 clear rest", r, 32'h0);

    // R11 event wins over simultaneous clear
    pulse_done(2);
    @(negedge clk);
    bus_addr = 5'h10; bus_wr = 1'b1; bus_wdata = 32'h4; ch_done[2] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; ch_done[2] = 1'b0;
    rd(5'h10, r);
    check("R11 event wins", r, 32'h0000_0004);
    wr(5'h10, 32'h4);

    // R12 interrupt = OR(flag AND enable)
    wr(5'h08, 32'h0000_0004);
    check("R12 irq idle", {31'b0, irq}, 32'h0);
    pulse_done(1);
    check("R12 masked flag", {31'b0, irq}, 32'h0);
    pulse_done(2);
    check("R12 enabled flag", {31'b0, irq}, 32'h1);
    wr(5'h10, 32'h4);
    check("R12 cleared", {31'b0, irq}, 32'h0);
    wr(5'h08, 32'h0000_0002);
    check("R12 enable pending", {31'b0, irq}, 32'h1);

    finished = 1'b1;
    summary();
  end
endmodule